// File: doc/BRIEF.md
# Nibble-Field Instruction Decoder and ALU

This block executes the arithmetic and logic part of a small processor whose instructions are two bytes wide and made of four 4-bit fields. The top nibble selects one of sixteen operation codes. The second nibble names the destination register. The low byte supplies either two register numbers, a register number plus a 4-bit unsigned immediate, or a single 8-bit source value. From the instruction the block drives three register-file read selects straight away, without a clock. A register file outside the block returns the three values in the same cycle.

On a clock edge with `in_valid` high, the block registers its results: the ALU result, the destination write enable and index, the decoded strobes for load, store, move-immediate and jump, and an illegal-opcode indication. It also keeps the 4-bit flag register and updates it for arithmetic, logic and shift operations. Memory access for loads and stores and all program-counter sequencing sit outside the block. For those it only supplies the address byte, the store data, the jump decision and the jump target value.

Top module: `nibcore`

## Requirements
- R1: The read selects follow `instr` in the same cycle: `rs_d_sel` = instr[11:8], `rs_a_sel` = instr[7:4], `rs_b_sel` = instr[3:0]. The opcode is instr[15:12].
- R2: Opcode 1 (add) gives A+B. Opcode 2 (subtract) gives A-B. For subtract, carry is set when no borrow occurs. Overflow is the signed 8-bit overflow of the operation.
- R3: Opcodes 3 (add immediate) and 4 (subtract immediate) use instr[3:0], zero-extended, in place of the B operand. Flags follow R2.
- R4: Opcodes 5 (and), 6 (or) and 7 (exclusive or) give the bitwise result and clear carry and overflow.
- R5: Opcodes 8 (shift left) and 9 (shift right, zero fill) shift A by the low 3 bits of B. Carry holds the last bit shifted out, or 0 when the amount is 0. Overflow is cleared.
- R6: The flag register is {zero, negative, carry, overflow} in bits 3:0, with zero and negative taken from the result. It changes only on an accepted opcode 1 to 9 and otherwise holds.
- R7: Opcodes 1 to 10 assert `wr_en` with `wr_sel` = destination, unless the destination is 15 (the zero register). Opcode 10 (move immediate) writes instr[7:0] and leaves the flags unchanged.
- R8: Opcode 11 (load) pulses `ld_go` and opcode 12 (store) pulses `st_go`, each with `mem_addr` = instr[7:0]. For a store, `res_data` carries the destination register's value. Neither asserts `wr_en`.
- R9: Opcode 13 (jump) pulses `jmp_go` only when the value read through `rs_a_sel` is nonzero. `jmp_target` carries the destination register's value.
- R10: Opcodes 14 and 15 raise `illegal` and otherwise act as no-operation: no write, no strobe and no flag change. Opcode 0 does nothing.
- R11: Results appear one clock after the accepted edge, with `out_valid` high. Without `in_valid`, the next cycle has `out_valid`, `wr_en`, all strobes and `illegal` low.
- R12: After reset, `flags` is 0 and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 16 | Instruction word |
| rs_a_data | input | 8 | Value of register selected by rs_a_sel |
| rs_b_data | input | 8 | Value of register selected by rs_b_sel |
| rs_d_data | input | 8 | Value of register selected by rs_d_sel |
| rs_a_sel | output | 4 | Register A read select |
| rs_b_sel | output | 4 | Register B read select |
| rs_d_sel | output | 4 | Destination-register read select |
| out_valid | output | 1 | Registered results valid |
| wr_en | output | 1 | Destination write enable |
| wr_sel | output | 4 | Destination register index |
| res_data | output | 8 | ALU result, move value or store data |
| flags | output | 4 | Flag register {Z,N,C,V} |
| ld_go | output | 1 | Load strobe |
| st_go | output | 1 | Store strobe |
| mvi_go | output | 1 | Move-immediate strobe |
| jmp_go | output | 1 | Jump taken |
| jmp_target | output | 8 | Jump target register value |
| mem_addr | output | 8 | Source byte used as load/store address |
| illegal | output | 1 | Illegal opcode seen |

## Verification
The assertions assume that reset is held for at least one edge with `in_valid` low. They also assume that the three register values are settled before each edge on which an instruction is accepted, since the zero-flag check compares the registered result with the updated flag. The bench drives every input at the falling edge and keeps `in_valid` low throughout reset. Random instructions draw all sixteen opcodes and all register values, so illegal codes and the zero-register destination come up alongside the directed corner cases.

// File: rtl/nibcore_pkg.sv
package nibcore_pkg;
  localparam int NIB = 4;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,  OP_ADD  = 4'd1,  OP_SUB  = 4'd2,  OP_ADDI = 4'd3,
    OP_SUBI = 4'd4,  OP_AND  = 4'd5,  OP_ORR  = 4'd6,  OP_EOR  = 4'd7,
    OP_LSL  = 4'd8,  OP_LSR  = 4'd9,  OP_MOVI = 4'd10, OP_LDR  = 4'd11,
    OP_STR  = 4'd12, OP_JMP  = 4'd13, OP_X14  = 4'd14, OP_X15  = 4'd15
  } op_e;

  typedef enum logic [1:0] {FMT_RR, FMT_RI, FMT_SRC, FMT_NONE} fmt_e;

  typedef enum logic [2:0] {
    FN_ADD, FN_SUB, FN_AND, FN_ORR, FN_EOR, FN_SHL, FN_SHR, FN_PASS
  } fn_e;

  typedef struct packed {
    fmt_e fmt;
    fn_e  fn;
    logic use_imm;
    logic alu_wr;
    logic flag_wr;
    logic mvi;
    logic ld;
    logic st;
    logic jmp;
    logic bad;
  } ctl_t;
endpackage

// File: rtl/nib_decode.sv
module nib_decode
  import nibcore_pkg::*;
(
  input  logic [15:0] instr,
  output logic [3:0]  f_dst,
  output logic [3:0]  f_ra,
  output logic [3:0]  f_rb,
  output logic [7:0]  f_src,
  output ctl_t        ctl
);
  op_e op;

  assign op    = op_e'(instr[15:12]);
  assign f_dst = instr[11:8];
  assign f_ra  = instr[7:4];
  assign f_rb  = instr[3:0];
  assign f_src = instr[7:0];

  always_comb begin
    ctl         = '0;
    ctl.fmt     = FMT_NONE;
    ctl.fn      = FN_PASS;
    unique case (op)
      OP_ADD, OP_SUB, OP_AND, OP_ORR, OP_EOR, OP_LSL, OP_LSR: begin
        ctl.fmt     = FMT_RR;
        ctl.alu_wr  = 1'b1;
        ctl.flag_wr = 1'b1;
      end
      OP_ADDI, OP_SUBI: begin
        ctl.fmt     = FMT_RI;
        ctl.use_imm = 1'b1;
        ctl.alu_wr  = 1'b1;
        ctl.flag_wr = 1'b1;
      end
      OP_MOVI: begin ctl.fmt = FMT_SRC; ctl.mvi = 1'b1; end
      OP_LDR:  begin ctl.fmt = FMT_SRC; ctl.ld  = 1'b1; end
      OP_STR:  begin ctl.fmt = FMT_SRC; ctl.st  = 1'b1; end
      OP_JMP:  begin ctl.fmt = FMT_RR;  ctl.jmp = 1'b1; end
      OP_X14, OP_X15: ctl.bad = 1'b1;
      default: ;
    endcase
    unique case (op)
      OP_ADD, OP_ADDI: ctl.fn = FN_ADD;
      OP_SUB, OP_SUBI: ctl.fn = FN_SUB;
      OP_AND:          ctl.fn = FN_AND;
      OP_ORR:          ctl.fn = FN_ORR;
      OP_EOR:          ctl.fn = FN_EOR;
      OP_LSL:          ctl.fn = FN_SHL;
      OP_LSR:          ctl.fn = FN_SHR;
      default:         ctl.fn = FN_PASS;
    endcase
  end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nibcore_pkg::*;
#(
  parameter int DW = 8
) (
  input  fn_e           fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic [3:0]    zncv
);
  localparam int SW = $clog2(DW);

  function automatic logic [DW+1:0] f_add(input logic [DW-1:0] x, input logic [DW-1:0] w);
    logic [DW:0] s;
    logic        ov;
    s  = {1'b0, x} + {1'b0, w};
    ov = (x[DW-1] == w[DW-1]) && (s[DW-1] != x[DW-1]);
    return {s[DW], ov, s[DW-1:0]};
  endfunction

  function automatic logic [DW+1:0] f_sub(input logic [DW-1:0] x, input logic [DW-1:0] w);
    logic [DW:0] s;
    logic        ov;
    s  = {1'b0, x} - {1'b0, w};
    ov = (x[DW-1] != w[DW-1]) && (s[DW-1] != x[DW-1]);
    return {~s[DW], ov, s[DW-1:0]};
  endfunction

  function automatic logic [DW:0] f_shl(input logic [DW-1:0] x, input logic [SW-1:0] k);
    logic [DW:0] e;
    e = {1'b0, x} << k;
    return e;
  endfunction

  function automatic logic [DW:0] f_shr(input logic [DW-1:0] x, input logic [SW-1:0] k);
    logic [DW:0] e;
    e = {x, 1'b0} >> k;
    return {e[0], e[DW:1]};
  endfunction

  logic [DW+1:0] r_add, r_sub;
  logic [DW:0]   r_shl, r_shr;
  logic          cy, ov;

  assign r_add = f_add(a, b);
  assign r_sub = f_sub(a, b);
  assign r_shl = f_shl(a, b[SW-1:0]);
  assign r_shr = f_shr(a, b[SW-1:0]);

  always_comb begin
    y  = a;
    cy = 1'b0;
    ov = 1'b0;
    unique case (fn)
      FN_ADD: begin y = r_add[DW-1:0]; cy = r_add[DW+1]; ov = r_add[DW]; end
      FN_SUB: begin y = r_sub[DW-1:0]; cy = r_sub[DW+1]; ov = r_sub[DW]; end
      FN_AND: y = a & b;
      FN_ORR: y = a | b;
      FN_EOR: y = a ^ b;
      FN_SHL: begin y = r_shl[DW-1:0]; cy = r_shl[DW]; end
      FN_SHR: begin y = r_shr[DW-1:0]; cy = r_shr[DW]; end
      default: y = a;
    endcase
  end

  assign zncv = {(y == '0), y[DW-1], cy, ov};
endmodule

// File: rtl/nibcore.sv
module nibcore
  import nibcore_pkg::*;
#(
  parameter int          DW     = 8,
  parameter logic [3:0]  ZR_IDX = 4'd15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [15:0]   instr,
  input  logic [DW-1:0] rs_a_data,
  input  logic [DW-1:0] rs_b_data,
  input  logic [DW-1:0] rs_d_data,
  output logic [3:0]    rs_a_sel,
  output logic [3:0]    rs_b_sel,
  output logic [3:0]    rs_d_sel,
  output logic          out_valid,
  output logic          wr_en,
  output logic [3:0]    wr_sel,
  output logic [DW-1:0] res_data,
  output logic [3:0]    flags,
  output logic          ld_go,
  output logic          st_go,
  output logic          mvi_go,
  output logic          jmp_go,
  output logic [DW-1:0] jmp_target,
  output logic [7:0]    mem_addr,
  output logic          illegal
);
  logic [3:0]    f_dst, f_ra, f_rb;
  logic [7:0]    f_src;
  ctl_t          ctl;
  logic [DW-1:0] imm_ext, src_ext, op_b, alu_y;
  logic [3:0]    alu_zncv;

  // named events for the checker
  logic flag_evt, write_evt, jump_evt;

  nib_decode u_dec (
    .instr (instr),
    .f_dst (f_dst),
    .f_ra  (f_ra),
    .f_rb  (f_rb),
    .f_src (f_src),
    .ctl   (ctl)
  );

  assign rs_a_sel = f_ra;
  assign rs_b_sel = f_rb;
  assign rs_d_sel = f_dst;

  always_comb begin
    imm_ext       = '0;
    imm_ext[3:0]  = f_rb;
    src_ext       = '0;
    src_ext[7:0]  = f_src;
  end

  assign op_b = ctl.use_imm ? imm_ext : rs_b_data;

  nib_alu #(.DW(DW)) u_alu (
    .fn   (ctl.fn),
    .a    (rs_a_data),
    .b    (op_b),
    .y    (alu_y),
    .zncv (alu_zncv)
  );

  assign flag_evt  = in_valid && ctl.flag_wr;
  assign write_evt = in_valid && (ctl.alu_wr || ctl.mvi) && (f_dst != ZR_IDX);
  assign jump_evt  = in_valid && ctl.jmp && (rs_a_data != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      wr_en      <= 1'b0;
      wr_sel     <= '0;
      res_data   <= '0;
      flags      <= '0;
      ld_go      <= 1'b0;
      st_go      <= 1'b0;
      mvi_go     <= 1'b0;
      jmp_go     <= 1'b0;
      jmp_target <= '0;
      mem_addr   <= '0;
      illegal    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= write_evt;
      ld_go     <= in_valid && ctl.ld;
      st_go     <= in_valid && ctl.st;
      mvi_go    <= in_valid && ctl.mvi;
      jmp_go    <= jump_evt;
      illegal   <= in_valid && ctl.bad;
      if (flag_evt) flags <= alu_zncv;
      if (in_valid) begin
        wr_sel     <= f_dst;
        jmp_target <= rs_d_data;
        mem_addr   <= f_src;
        if (ctl.st)       res_data <= rs_d_data;
        else if (ctl.mvi) res_data <= src_ext;
        else              res_data <= alu_y;
      end
    end
  end
endmodule

// File: rtl/nibcore_chk.sv
module nibcore_chk #(
  parameter int         DW     = 8,
  parameter logic [3:0] ZR_IDX = 4'd15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [15:0]   instr,
  input logic          out_valid,
  input logic          wr_en,
  input logic [3:0]    wr_sel,
  input logic [DW-1:0] res_data,
  input logic [3:0]    flags,
  input logic          ld_go,
  input logic          st_go,
  input logic          mvi_go,
  input logic          jmp_go,
  input logic          illegal,
  input logic          flag_evt
);
  // R7
  zr_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_sel != ZR_IDX));

  // R11
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !wr_en && !ld_go && !st_go && !mvi_go && !jmp_go && !illegal));

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_evt |=> $stable(flags));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_evt |=> (flags[3] == (res_data == '0)));

  // R10
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[15:13] == 3'b111) |=> (illegal && !wr_en && $stable(flags)));

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_go, st_go, mvi_go, jmp_go, illegal}));
endmodule

bind nibcore nibcore_chk #(.DW(DW), .ZR_IDX(ZR_IDX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .instr     (instr),
  .out_valid (out_valid),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .res_data  (res_data),
  .flags     (flags),
  .ld_go     (ld_go),
  .st_go     (st_go),
  .mvi_go    (mvi_go),
  .jmp_go    (jmp_go),
  .illegal   (illegal),
  .flag_evt  (flag_evt)
);

// File: tb/sim_nibcore.sv
module sim_nibcore;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [7:0]  rs_a_data = '0, rs_b_data = '0, rs_d_data = '0;
  logic [3:0]  rs_a_sel, rs_b_sel, rs_d_sel, wr_sel, flags;
  logic        out_valid, wr_en, ld_go, st_go, mvi_go, jmp_go, illegal;
  logic [7:0]  res_data, jmp_target, mem_addr;

  int total = 0;
  int bad = 0;
  logic [3:0] mflags = 4'h0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nibcore u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .rs_a_data(rs_a_data), .rs_b_data(rs_b_data), .rs_d_data(rs_d_data),
    .rs_a_sel(rs_a_sel), .rs_b_sel(rs_b_sel), .rs_d_sel(rs_d_sel),
    .out_valid(out_valid), .wr_en(wr_en), .wr_sel(wr_sel), .res_data(res_data),
    .flags(flags), .ld_go(ld_go), .st_go(st_go), .mvi_go(mvi_go), .jmp_go(jmp_go),
    .jmp_target(jmp_target), .mem_addr(mem_addr), .illegal(illegal)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: returns {flags_next, result}
  function automatic logic [11:0] model(input int op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [3:0] fl);
    int r, sa, sb, sr;
    logic c, v;
    logic [7:0] x;
    c = 0; v = 0; r = 0;
    sa = int'($signed(a)); sb = int'($signed(b));
    case (op)
      1, 3: begin r = int'(a) + int'(b); c = (r > 255); sr = sa + sb; v = (sr > 127) || (sr < -128); end
      2, 4: begin r = int'(a) - int'(b); c = (a >= b); sr = sa - sb; v = (sr > 127) || (sr < -128); end
      5: r = int'(a & b);
      6: r = int'(a | b);
      7: r = int'(a ^ b);
      8: begin x = a; for (int i = 0; i < int'(b[2:0]); i++) begin c = x[7]; x = x << 1; end r = int'(x); end
      9: begin x = a; for (int i = 0; i < int'(b[2:0]); i++) begin c = x[0]; x = x >> 1; end r = int'(x); end
      default: return {fl, 8'h00};
    endcase
    x = r[7:0];
    return {(x == 8'h00), x[7], c, v, x};
  endfunction

  task automatic run(input logic [3:0] op, input logic [3:0] dst, input logic [7:0] lo,
                     input logic [7:0] av, input logic [7:0] bv, input logic [7:0] dv);
    logic [11:0] m;
    logic [7:0]  b;
    int o;
    o = int'(op);
    @(negedge clk);
    in_valid = 1'b1;
    instr = {op, dst, lo};
    rs_a_data = av; rs_b_data = bv; rs_d_data = dv;
    #1;
    chk("R1 a_sel", rs_a_sel, lo[7:4]);
    chk("R1 b_sel", rs_b_sel, lo[3:0]);
    chk("R1 d_sel", rs_d_sel, dst);
    b = (o == 3 || o == 4) ? {4'h0, lo[3:0]} : bv;
    m = model(o, av, b, mflags);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 out_valid", out_valid, 1);
    if (o >= 1 && o <= 9) begin
      mflags = m[11:8];
      chk((o <= 2) ? "R2 result" : (o <= 4) ? "R3 result" : (o <= 7) ? "R4 result" : "R5 result",
          res_data, m[7:0]);
    end
    chk("R6 flags", flags, mflags);
    chk("R7 wr_en", wr_en, (o >= 1 && o <= 10 && dst != 4'd15));
    if (o >= 1 && o <= 10) chk("R7 wr_sel", wr_sel, dst);
    if (o == 10) chk("R7 move value", res_data, lo);
    chk("R8 ld_go", ld_go, o == 11);
    chk("R8 st_go", st_go, o == 12);
    chk("R7 mvi_go", mvi_go, o == 10);
    if (o == 11 || o == 12) chk("R8 mem_addr", mem_addr, lo);
    if (o == 12) chk("R8 store data", res_data, dv);
    chk("R9 jmp_go", jmp_go, (o == 13) && (av != 0));
    if (o == 13) chk("R9 target", jmp_target, dv);
    chk("R10 illegal", illegal, o >= 14);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 flags reset", flags, 0);
    chk("R12 out_valid reset", out_valid, 0);
    rst_n = 1'b1;
    // directed corners
    run(4'd1, 4'd2, 8'h12, 8'h7F, 8'h01, 8'h00); // R2 signed overflow
    run(4'd1, 4'd2, 8'h12, 8'hFF, 8'h01, 8'h00); // R2 carry and zero
    run(4'd2, 4'd3, 8'h12, 8'h05, 8'h05, 8'h00); // R2 zero, no borrow
    run(4'd2, 4'd3, 8'h12, 8'h03, 8'h05, 8'h00); // R2 borrow, negative
    run(4'd2, 4'd3, 8'h12, 8'h80, 8'h01, 8'h00); // R2 overflow
    run(4'd3, 4'd4, 8'h1F, 8'hF1, 8'h00, 8'h00); // R3 imm 15
    run(4'd4, 4'd4, 8'h1F, 8'h0E, 8'hAA, 8'h00); // R3 borrow by imm
    run(4'd6, 4'd5, 8'h12, 8'hF0, 8'h0F, 8'h00); // R4 or clears C,V
    run(4'd8, 4'd1, 8'h12, 8'h81, 8'h08, 8'h00); // R5 amount 0
    run(4'd8, 4'd1, 8'h12, 8'h81, 8'h01, 8'h00); // R5 left carry
    run(4'd9, 4'd1, 8'h12, 8'h81, 8'h07, 8'h00); // R5 right by 7
    run(4'd1, 4'd15, 8'h12, 8'h01, 8'h01, 8'h00); // R7 zero dest, flags update
    run(4'd10, 4'd6, 8'hA5, 8'h00, 8'h00, 8'h00); // R7 move immediate
    run(4'd11, 4'd6, 8'h3C, 8'h00, 8'h00, 8'h00); // R8 load
    run(4'd12, 4'd6, 8'hC3, 8'h00, 8'h00, 8'h5A); // R8 store
    run(4'd13, 4'd7, 8'h12, 8'h00, 8'h00, 8'h44); // R9 not taken
    run(4'd13, 4'd7, 8'h12, 8'h01, 8'h00, 8'h44); // R9 taken
    run(4'd14, 4'd2, 8'h12, 8'h01, 8'h01, 8'h00); // R10
    run(4'd15, 4'd2, 8'h12, 8'h01, 8'h01, 8'h00); // R10
    run(4'd0, 4'd2, 8'h12, 8'h01, 8'h01, 8'h00);  // R10 nop
    // idle cycle: R11 quiet, R6 hold
    @(negedge clk);
    chk("R11 idle out_valid", out_valid, 0);
    chk("R6 idle flags", flags, mflags);
    for (int i = 0; i < 400; i++) begin
      run(4'($urandom), 4'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule